// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Interface

This block is the digital front end of a 16-bit converter with a parallel bus. A host owns a bidirectional data bus plus five control pins: an active-low chip select, a read/write direction pin, a load strobe, a preset pin and a preset-level select. All pins are asynchronous to the block's system clock. The block stages a word in an input register, which the host can also read back. A load edge moves the staged word into the output (DAC) register, whose code drives a downstream converter model.

Because the registers are double-buffered, the host can stage a new word at any time while the converter keeps its old code. Several converters can therefore be updated together by one shared load strobe. A preset edge forces both registers to mid-scale or to zero. Every pin passes through a two-flop synchronizer, so each action lands a fixed number of clock edges after the pins change.

Top module: `dac_bus_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, both registers hold 0000h, `code_o` is 0000h and the block does not drive `bus_io`.
- R2: When `cs_ni` is low and `rd_wr_i` is low, the word on `bus_io` is written into the input register. The word is straight binary, and bus bit i lands in register bit i (bit 15 is the MSB). The write takes effect on the third rising clock edge after the pins change: two synchronizer edges, then the capture edge.
- R3: When `cs_ni` is low and `rd_wr_i` is high, the block drives the input register (not the DAC register) onto `bus_io`. Whenever `cs_ni` is high the block leaves `bus_io` undriven.
- R4: A rising edge on `load_i` copies the input register into the DAC register (`code_o`) once. Holding `load_i` at a steady high or low level copies nothing more.
- R5: A write with no load edge changes the input register only. `code_o` keeps its previous value.
- R6: A rising edge on `preset_i` while `preset_mid_i` is high sets both registers to 8000h.
- R7: A rising edge on `preset_i` while `preset_mid_i` is low sets both registers to 0000h.
- R8: When a preset edge falls in the same cycle as a write and a load edge, the preset wins: both registers take the preset code, and that load edge is not applied.
- R9: A steady high level on `preset_i` has no effect after its edge, so writes proceed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| bus_io | inout | 16 | Bidirectional parallel data bus |
| cs_ni | input | 1 | Chip select, active low |
| rd_wr_i | input | 1 | Direction: 1 reads back, 0 writes |
| load_i | input | 1 | Load strobe, acts on its rising edge |
| preset_i | input | 1 | Preset pin, acts on its rising edge |
| preset_mid_i | input | 1 | Preset level: 1 gives mid-scale, 0 gives zero |
| code_o | output | 16 | DAC register code for the converter |

## Verification
The bench drives several patterns. Distinct words such as A5C3h, 0F0Fh and 1357h are written with and without a following load edge, which separates the staged register from the output register. A write made while the load strobe is held high shows that only edges transfer data. Presets are issued with the select in both states, once with the preset pin left high during a later write, and once in the same cycle as a write and a load edge, which exposes the priority order. To check that the bus is released, the bench drives zero onto it while chip select is high; any drive from the block would corrupt that word.

// File: rtl/dac_bus_pkg.sv
package dac_bus_pkg;

  typedef struct packed {
    logic cs_n;
    logic rd;
    logic load;
    logic preset;
    logic mid;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, rd: 1'b1, load: 1'b0, preset: 1'b0, mid: 1'b0};

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rise_det.sv
module rise_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/dac_reg_core.sv
module dac_reg_core #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_rise_i,
  input  logic          preset_rise_i,
  input  logic          preset_mid_i,
  output logic [DW-1:0] in_q_o,
  output logic [DW-1:0] code_q_o
);
  localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] preset_code;
  assign preset_code = preset_mid_i ? MID_CODE : '0;

  // preset edge beats write and load in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o   <= '0;
      code_q_o <= '0;
    end else if (preset_rise_i) begin
      in_q_o   <= preset_code;
      code_q_o <= preset_code;
    end else begin
      if (wr_en_i)     in_q_o   <= wr_data_i;
      if (load_rise_i) code_q_o <= in_q_o;
    end
  end
endmodule

// File: rtl/dac_bus_ctrl.sv
module dac_bus_ctrl
  import dac_bus_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  inout  wire [DW-1:0]  bus_io,
  input  logic          cs_ni,
  input  logic          rd_wr_i,
  input  logic          load_i,
  input  logic          preset_i,
  input  logic          preset_mid_i,
  output logic [DW-1:0] code_o
);
  ctl_t          ctl_raw, ctl_s;
  logic [DW-1:0] data_s, in_q;
  logic          wr_en, bus_oe, load_rise, preset_rise;

  assign ctl_raw = '{cs_n: cs_ni, rd: rd_wr_i, load: load_i, preset: preset_i, mid: preset_mid_i};

  pin_sync #(.W($bits(ctl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) i_ctl_sync (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s)
  );

  // data follows the same latency as the controls
  pin_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_data_sync (
    .clk_i, .rst_ni, .d_i(bus_io), .q_o(data_s)
  );

  rise_det #(.W(2)) i_edges (
    .clk_i, .rst_ni,
    .d_i({ctl_s.load, ctl_s.preset}),
    .rise_o({load_rise, preset_rise})
  );

  assign wr_en  = ~ctl_s.cs_n & ~ctl_s.rd;
  assign bus_oe = ~ctl_s.cs_n &  ctl_s.rd;

  dac_reg_core #(.DW(DW)) i_core (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(data_s),
    .load_rise_i(load_rise), .preset_rise_i(preset_rise), .preset_mid_i(ctl_s.mid),
    .in_q_o(in_q), .code_q_o(code_o)
  );

  assign bus_io = bus_oe ? in_q : {DW{1'bz}};
endmodule

// File: rtl/dac_bus_checker.sv
module dac_bus_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] code_i,
  input logic [DW-1:0] in_q_i,
  input logic          wr_en_i,
  input logic          oe_i,
  input logic          load_rise_i,
  input logic          preset_rise_i,
  input logic          mid_i
);
  localparam logic [DW-1:0] MID_CODE = {1'b1, {(DW-1){1'b0}}};

  p_init_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> (code_i == '0 && in_q_i == '0));

  p_in_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !preset_rise_i) |=> $stable(in_q_i));

  p_dir_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_i && wr_en_i));

  p_load_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_rise_i && !preset_rise_i) |=> code_i == $past(in_q_i));

  p_code_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_rise_i && !preset_rise_i) |=> $stable(code_i));

  p_preset_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_rise_i && mid_i) |=> (code_i == MID_CODE && in_q_i == MID_CODE));

  p_preset_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_rise_i && !mid_i) |=> (code_i == '0 && in_q_i == '0));

  // R8: priority over a concurrent write
  p_preset_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_rise_i && wr_en_i) |=> in_q_i == code_i);
endmodule

bind dac_bus_ctrl dac_bus_checker #(.DW(DW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_o), .in_q_i(in_q),
  .wr_en_i(wr_en), .oe_i(bus_oe), .load_rise_i(load_rise),
  .preset_rise_i(preset_rise), .mid_i(ctl_s.mid)
);

// File: tb/test_dac_bus_ctrl.sv
module test_dac_bus_ctrl;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic        cs_n, rd, ld, pr, mid;
    logic [15:0] d;
  } sample_t;

  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, rd = 1, load = 0, preset = 0, mid = 0;
  logic        drv_en = 0;
  logic [15:0] drv_val = '0;
  wire  [15:0] bus_w;
  logic [15:0] code;

  int checks = 0, fails = 0;

  assign bus_w = drv_en ? drv_val : 16'hzzzz;

  dac_bus_ctrl i_dac_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_io(bus_w), .cs_ni(cs_n), .rd_wr_i(rd),
    .load_i(load), .preset_i(preset), .preset_mid_i(mid), .code_o(code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: pin history, actions two samples late
  sample_t     hist[$];
  logic [15:0] m_in, m_code;

  function automatic sample_t idle_s();
    sample_t s;
    s.cs_n = 1; s.rd = 1; s.ld = 0; s.pr = 0; s.mid = 0; s.d = '0;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {idle_s(), idle_s(), idle_s()};
      m_in = '0; m_code = '0;
    end else begin
      sample_t s, s2, s3;
      logic [15:0] old_in;
      s.cs_n = cs_n; s.rd = rd; s.ld = load; s.pr = preset; s.mid = mid; s.d = bus_w;
      hist.push_front(s);
      s2 = hist[2]; s3 = hist[3];
      void'(hist.pop_back());
      old_in = m_in;
      if (s2.pr && !s3.pr) begin
        m_in = s2.mid ? 16'h8000 : 16'h0000;
        m_code = m_in;
      end else begin
        if (!s2.cs_n && !s2.rd) m_in = s2.d;
        if (s2.ld && !s3.ld) m_code = old_in;
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 model code", code, m_code);
      if (!hist[1].cs_n && hist[1].rd && !drv_en) chk("R3 model readback", bus_w, m_in);
    end
  end

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_word(logic [15:0] d);
    settle(1);
    drv_en = 1; drv_val = d; cs_n = 0; rd = 0;
    settle(2);
    cs_n = 1; rd = 1; drv_en = 0;
    settle(4);
  endtask

  task automatic read_check(string tag, logic [15:0] exp);
    cs_n = 0; rd = 1;
    settle(3);
    @(negedge clk);
    chk(tag, bus_w, exp);
    settle(1);
    cs_n = 1;
    settle(3);
  endtask

  task automatic pulse_load();
    load = 1; settle(4);
    load = 0; settle(4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    settle(3);
    @(negedge clk); chk("R1 code in reset", code, 16'h0000);
    rst_n = 1;
    settle(2);
    @(negedge clk); chk("R1 code after reset", code, 16'h0000);
    settle(1);
    read_check("R1 input register after reset", 16'h0000);

    write_word(16'hA5C3);
    @(negedge clk); chk("R5 code unchanged by write", code, 16'h0000);
    settle(1);
    read_check("R2 write A5C3 readback", 16'hA5C3);

    // released bus: bench drives zero with chip select high
    drv_en = 1; drv_val = 16'h0000; cs_n = 1; rd = 1;
    settle(4);
    @(negedge clk); chk("R3 bus released when deselected", bus_w, 16'h0000);
    settle(1); drv_en = 0; settle(2);

    pulse_load();
    @(negedge clk); chk("R4 load edge copies", code, 16'hA5C3);
    settle(1);

    load = 1; settle(4);
    write_word(16'h0F0F);
    @(negedge clk); chk("R4 steady load level ignored", code, 16'hA5C3);
    settle(1);
    load = 0; settle(3);
    load = 1; settle(4);
    @(negedge clk); chk("R4 second edge copies", code, 16'h0F0F);
    settle(1); load = 0; settle(3);

    write_word(16'h1357);
    @(negedge clk); chk("R5 staged word not loaded", code, 16'h0F0F);
    settle(1);
    read_check("R3 readback gives input register", 16'h1357);

    mid = 1; settle(2);
    preset = 1; settle(4);
    @(negedge clk); chk("R6 mid-scale preset code", code, 16'h8000);
    settle(1);
    read_check("R6 mid-scale preset input", 16'h8000);

    write_word(16'h2222);
    read_check("R9 write with preset held high", 16'h2222);
    @(negedge clk); chk("R9 code kept with preset held", code, 16'h8000);
    settle(1);
    preset = 0; settle(3);

    mid = 0; settle(2);
    preset = 1; settle(4);
    @(negedge clk); chk("R7 zero preset code", code, 16'h0000);
    settle(1);
    read_check("R7 zero preset input", 16'h0000);
    preset = 0; settle(3);

    write_word(16'h4444);
    mid = 1; settle(2);
    drv_en = 1; drv_val = 16'hBEEF; cs_n = 0; rd = 0; load = 1; preset = 1;
    settle(4);
    cs_n = 1; rd = 1; drv_en = 0; load = 0; preset = 0;
    settle(4);
    @(negedge clk); chk("R8 preset wins over load", code, 16'h8000);
    settle(1);
    read_check("R8 write after preset edge", 16'hBEEF);

    finish_run();
  end
endmodule